// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block carries out a single analog-to-digital measurement command for a small coprocessor. A command names one of four general registers (R0 to R3) as the destination, picks one of two successive-approximation converters, and gives a pad operand. Once the block accepts the command, it turns on the enable line of the chosen pad on the chosen converter and steps through a fixed overhead. Three amplifier settle waits follow, then a sample phase and a bit-conversion phase. The converter output is taken at the end of conversion and handed to the register file over a one-cycle write-back port. A four-cycle fetch tail then runs, and a done pulse ends the command.

The controller is a state machine with the states IDLE, OVH, AMP1, AMP2, AMP3, SAMP, CONV and FETCH. Its transitions are:

- IDLE to OVH when a command is accepted.
- OVH to AMP1, AMP1 to AMP2, and AMP2 to AMP3.
- AMP3 to SAMP. If the sample count is zero it goes to CONV instead, and if the bit count is also zero it goes to FETCH.
- SAMP to CONV, or to FETCH if the bit count is zero.
- CONV to FETCH.
- FETCH to IDLE.

Every state other than IDLE leaves when its down-counter reaches zero. The counter is loaded with the length of the next state as that state is entered.

The pad operand is offset by one: operand p turns on pad p-1. Operand 0, and any operand above the pad count, is illegal. An illegal command keeps the normal timing but enables no pad, writes nothing back, and raises an error flag together with done.

Top module: `sar_conv_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, both pad enable vectors, adc_sample, adc_convert, wb_en, done and pad_err are all 0.
- R2: A command is accepted on a clock edge where cmd_valid is 1 and busy is 0. Let E = 23 + max(1,A1) + max(1,A2) + max(1,A3) + S + B, where A1..A3, S and B are the settings at acceptance. busy is then 1 for exactly E + 4 cycles, starting in the cycle after acceptance.
- R3: The phases run in a fixed order: 23 overhead cycles, then each amplifier wait for max(1,An) cycles, then S cycles with adc_sample high, then B cycles with adc_convert high. A phase whose count is zero is skipped.
- R4: For a pad operand p with 1 <= p <= NPADS, bit p-1 of the selected converter's enable vector is high in execution cycles 1..E and low otherwise. No other enable bit is ever high.
- R5: Converter select 0 drives pad_en_a and takes its result from adc_res_a. Select 1 drives pad_en_b and takes adc_res_b. The unselected vector stays 0.
- R6: The result is sampled on the edge that ends execution cycle E. In cycle E+1, wb_en is high for one cycle, with wb_idx equal to the destination operand (0..3) and wb_data equal to the sampled result.
- R7: done is high for exactly one cycle, the last busy cycle (E+4). busy is 0 in the next cycle.
- R8: A pad operand of 0 or above NPADS enables no pad and produces no wb_en, with unchanged timing. pad_err is high in the done cycle.
- R9: cmd_valid asserted while busy is ignored. Neither the running command's timing nor its destination, converter or pad changes.
- R10: The settings are captured at acceptance. Changes to cfg_* during a command have no effect on that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_dst | input | 2 | Destination register index R0..R3 |
| cmd_unit | input | 1 | Converter select: 0 first, 1 second |
| cmd_pad | input | PAD_W | Pad operand (pad p-1 enabled) |
| cfg_amp1 | input | WAIT_W | First amplifier settle wait |
| cfg_amp2 | input | WAIT_W | Second amplifier settle wait |
| cfg_amp3 | input | WAIT_W | Third amplifier settle wait |
| cfg_smp_cyc | input | SMP_W | Sample phase length |
| cfg_bit_cyc | input | SMP_W | Bit-conversion phase length |
| adc_res_a | input | RES_W | Result of the first converter |
| adc_res_b | input | RES_W | Result of the second converter |
| busy | output | 1 | Command in progress |
| pad_en_a | output | NPADS | Pad enables, first converter |
| pad_en_b | output | NPADS | Pad enables, second converter |
| adc_sample | output | 1 | Sample phase strobe |
| adc_convert | output | 1 | Bit-conversion phase strobe |
| wb_en | output | 1 | Register write-back strobe |
| wb_idx | output | 2 | Write-back register index |
| wb_data | output | RES_W | Write-back data |
| done | output | 1 | Command complete pulse |
| pad_err | output | 1 | Illegal pad operand, with done |

## Verification
Two situations are hard to reach from the ports. The first is a second command that arrives, together with fresh settings, while one is already running. The second is a phase sequence where the sample or conversion count is zero, so a state must be skipped. In every command, the stimulus raises cmd_valid in the third busy cycle with random fields and random settings. The expected timeline is still derived from the values captured at acceptance. Random settings include zero waits and zero sample and bit counts, and directed commands cover both skips, the clamps, the first and last legal pad, and both kinds of illegal pad. The converter results change every cycle, so only a capture on the exact final execution edge matches.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OVH,
        ST_AMP1,
        ST_AMP2,
        ST_AMP3,
        ST_SAMP,
        ST_CONV,
        ST_FETCH
    } seq_state_e;

endpackage

// File: rtl/sar_pad_decode.sv
module sar_pad_decode #(
    parameter int NPADS = 10,
    parameter int PAD_W = 4
) (
    input  logic [PAD_W-1:0] pad_op,
    output logic [NPADS-1:0] pad_hot,
    output logic             pad_ok
);

    // operand p selects line p-1; operand 0 and out-of-range match nothing
    for (genvar i = 0; i < NPADS; i++) begin : g_line
        assign pad_hot[i] = (pad_op == PAD_W'(i + 1));
    end

    assign pad_ok = |pad_hot;

endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_seq_pkg::*;
#(
    parameter int WAIT_W    = 8,
    parameter int SMP_W     = 8,
    parameter int PAD_W     = 4,
    parameter int OVH_CYC   = 23,
    parameter int FETCH_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_dst,
    input  logic              cmd_unit,
    input  logic [PAD_W-1:0]  cmd_pad,
    input  logic [WAIT_W-1:0] cfg_amp1,
    input  logic [WAIT_W-1:0] cfg_amp2,
    input  logic [WAIT_W-1:0] cfg_amp3,
    input  logic [SMP_W-1:0]  cfg_smp_cyc,
    input  logic [SMP_W-1:0]  cfg_bit_cyc,
    output logic              busy,
    output logic              exec_on,
    output logic              smp_on,
    output logic              conv_on,
    output logic              cap,
    output logic              done,
    output logic [1:0]        dst_q,
    output logic              unit_q,
    output logic [PAD_W-1:0]  pad_q
);

    localparam int CFG_W   = (WAIT_W > SMP_W) ? WAIT_W : SMP_W;
    localparam int OVH_W   = $clog2(OVH_CYC + 1);
    localparam int FET_W   = $clog2(FETCH_CYC + 1);
    localparam int FIX_W   = (OVH_W > FET_W) ? OVH_W : FET_W;
    localparam int CTR_W   = (CFG_W > FIX_W) ? CFG_W : FIX_W;

    seq_state_e        state_q, state_d, follow;
    logic [CTR_W-1:0]  cnt_q, cnt_d, follow_len;
    logic [WAIT_W-1:0] a1_q, a2_q, a3_q;
    logic [SMP_W-1:0]  smp_q, bits_q;
    logic              advance, accept;

    function automatic logic [CTR_W-1:0] amp_len(input logic [WAIT_W-1:0] w);
        return (w == '0) ? CTR_W'(1) : CTR_W'(w);
    endfunction

    assign accept  = (state_q == ST_IDLE) && cmd_valid;
    assign advance = (state_q == ST_IDLE) ? cmd_valid : (cnt_q == '0);

    // successor of the current state, skipping empty phases
    always_comb begin : follow_p
        unique case (state_q)
            ST_IDLE:  follow = ST_OVH;
            ST_OVH:   follow = ST_AMP1;
            ST_AMP1:  follow = ST_AMP2;
            ST_AMP2:  follow = ST_AMP3;
            ST_AMP3:  follow = (smp_q != '0)  ? ST_SAMP :
                               (bits_q != '0) ? ST_CONV : ST_FETCH;
            ST_SAMP:  follow = (bits_q != '0) ? ST_CONV : ST_FETCH;
            ST_CONV:  follow = ST_FETCH;
            ST_FETCH: follow = ST_IDLE;
            default:  follow = ST_IDLE;
        endcase
    end

    always_comb begin : len_p
        unique case (follow)
            ST_OVH:   follow_len = CTR_W'(OVH_CYC);
            ST_AMP1:  follow_len = amp_len(a1_q);
            ST_AMP2:  follow_len = amp_len(a2_q);
            ST_AMP3:  follow_len = amp_len(a3_q);
            ST_SAMP:  follow_len = CTR_W'(smp_q);
            ST_CONV:  follow_len = CTR_W'(bits_q);
            ST_FETCH: follow_len = CTR_W'(FETCH_CYC);
            default:  follow_len = CTR_W'(1);
        endcase
    end

    always_comb begin : next_p
        state_d = state_q;
        cnt_d   = cnt_q;
        if (advance) begin
            state_d = follow;
            cnt_d   = follow_len - 1'b1;
        end else begin
            cnt_d   = cnt_q - 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin : state_r
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // operand and setting capture at acceptance only
    always_ff @(posedge clk or negedge rst_n) begin : latch_r
        if (!rst_n) begin
            dst_q  <= '0;
            unit_q <= 1'b0;
            pad_q  <= '0;
            a1_q   <= '0;
            a2_q   <= '0;
            a3_q   <= '0;
            smp_q  <= '0;
            bits_q <= '0;
        end else if (accept) begin
            dst_q  <= cmd_dst;
            unit_q <= cmd_unit;
            pad_q  <= cmd_pad;
            a1_q   <= cfg_amp1;
            a2_q   <= cfg_amp2;
            a3_q   <= cfg_amp3;
            smp_q  <= cfg_smp_cyc;
            bits_q <= cfg_bit_cyc;
        end
    end

    // outputs
    always_comb begin : out_p
        busy    = 1'b0;
        exec_on = 1'b0;
        smp_on  = 1'b0;
        conv_on = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_OVH, ST_AMP1, ST_AMP2, ST_AMP3: begin
                busy    = 1'b1;
                exec_on = 1'b1;
            end
            ST_SAMP: begin
                busy    = 1'b1;
                exec_on = 1'b1;
                smp_on  = 1'b1;
            end
            ST_CONV: begin
                busy    = 1'b1;
                exec_on = 1'b1;
                conv_on = 1'b1;
            end
            ST_FETCH: begin
                busy = 1'b1;
                done = (cnt_q == '0);
            end
            default: ;
        endcase
        cap = exec_on && advance && (follow == ST_FETCH);
    end

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) && cmd_valid |=>
            $stable(dst_q) && $stable(unit_q) && $stable(pad_q));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && (state_q == ST_IDLE));

    // R3
    samp_then_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(smp_on) |-> (state_q == ST_CONV) || (state_q == ST_FETCH));

endmodule

// File: rtl/sar_wb_reg.sv
module sar_wb_reg #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic             legal,
    input  logic             unit,
    input  logic [1:0]       dst,
    input  logic [RES_W-1:0] res_a,
    input  logic [RES_W-1:0] res_b,
    output logic             wb_en,
    output logic [1:0]       wb_idx,
    output logic [RES_W-1:0] wb_data
);

    always_ff @(posedge clk or negedge rst_n) begin : wb_r
        if (!rst_n) begin
            wb_en   <= 1'b0;
            wb_idx  <= '0;
            wb_data <= '0;
        end else begin
            wb_en <= cap && legal;
            if (cap) begin
                wb_idx  <= dst;
                wb_data <= unit ? res_b : res_a;
            end
        end
    end

    // R6
    wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> !wb_en);

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
    parameter int NPADS     = 10,
    parameter int PAD_W     = $clog2(NPADS + 1),
    parameter int WAIT_W    = 8,
    parameter int SMP_W     = 8,
    parameter int RES_W     = 12,
    parameter int OVH_CYC   = 23,
    parameter int FETCH_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_dst,
    input  logic              cmd_unit,
    input  logic [PAD_W-1:0]  cmd_pad,
    input  logic [WAIT_W-1:0] cfg_amp1,
    input  logic [WAIT_W-1:0] cfg_amp2,
    input  logic [WAIT_W-1:0] cfg_amp3,
    input  logic [SMP_W-1:0]  cfg_smp_cyc,
    input  logic [SMP_W-1:0]  cfg_bit_cyc,
    input  logic [RES_W-1:0]  adc_res_a,
    input  logic [RES_W-1:0]  adc_res_b,
    output logic              busy,
    output logic [NPADS-1:0]  pad_en_a,
    output logic [NPADS-1:0]  pad_en_b,
    output logic              adc_sample,
    output logic              adc_convert,
    output logic              wb_en,
    output logic [1:0]        wb_idx,
    output logic [RES_W-1:0]  wb_data,
    output logic              done,
    output logic              pad_err
);

    logic             exec_on, cap, unit_q, pad_ok;
    logic [1:0]       dst_q;
    logic [PAD_W-1:0] pad_q;
    logic [NPADS-1:0] pad_hot;

    sar_seq_fsm #(
        .WAIT_W    (WAIT_W),
        .SMP_W     (SMP_W),
        .PAD_W     (PAD_W),
        .OVH_CYC   (OVH_CYC),
        .FETCH_CYC (FETCH_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_dst     (cmd_dst),
        .cmd_unit    (cmd_unit),
        .cmd_pad     (cmd_pad),
        .cfg_amp1    (cfg_amp1),
        .cfg_amp2    (cfg_amp2),
        .cfg_amp3    (cfg_amp3),
        .cfg_smp_cyc (cfg_smp_cyc),
        .cfg_bit_cyc (cfg_bit_cyc),
        .busy        (busy),
        .exec_on     (exec_on),
        .smp_on      (adc_sample),
        .conv_on     (adc_convert),
        .cap         (cap),
        .done        (done),
        .dst_q       (dst_q),
        .unit_q      (unit_q),
        .pad_q       (pad_q)
    );

    sar_pad_decode #(
        .NPADS (NPADS),
        .PAD_W (PAD_W)
    ) u_dec (
        .pad_op  (pad_q),
        .pad_hot (pad_hot),
        .pad_ok  (pad_ok)
    );

    sar_wb_reg #(
        .RES_W (RES_W)
    ) u_wb (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (cap),
        .legal   (pad_ok),
        .unit    (unit_q),
        .dst     (dst_q),
        .res_a   (adc_res_a),
        .res_b   (adc_res_b),
        .wb_en   (wb_en),
        .wb_idx  (wb_idx),
        .wb_data (wb_data)
    );

    assign pad_en_a = (exec_on && !unit_q) ? pad_hot : '0;
    assign pad_en_b = (exec_on &&  unit_q) ? pad_hot : '0;
    assign pad_err  = done && !pad_ok;

    // R4
    pad_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pad_en_b, pad_en_a}));

    // R8
    bad_pad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !pad_ok |-> (pad_en_a == '0) && (pad_en_b == '0) && !wb_en);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wb_en && !adc_sample && !adc_convert && !done);

endmodule

// File: tb/sar_conv_seq_test.sv
module sar_conv_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_dst = '0;
    logic        cmd_unit = 1'b0;
    logic [3:0]  cmd_pad = '0;
    logic [7:0]  cfg_amp1 = '0, cfg_amp2 = '0, cfg_amp3 = '0;
    logic [7:0]  cfg_smp_cyc = '0, cfg_bit_cyc = '0;
    logic [11:0] adc_res_a = '0, adc_res_b = '0;
    logic        busy, adc_sample, adc_convert, wb_en, done, pad_err;
    logic [9:0]  pad_en_a, pad_en_b;
    logic [1:0]  wb_idx;
    logic [11:0] wb_data;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    sar_conv_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_dst(cmd_dst),
        .cmd_unit(cmd_unit), .cmd_pad(cmd_pad), .cfg_amp1(cfg_amp1),
        .cfg_amp2(cfg_amp2), .cfg_amp3(cfg_amp3), .cfg_smp_cyc(cfg_smp_cyc),
        .cfg_bit_cyc(cfg_bit_cyc), .adc_res_a(adc_res_a), .adc_res_b(adc_res_b),
        .busy(busy), .pad_en_a(pad_en_a), .pad_en_b(pad_en_b),
        .adc_sample(adc_sample), .adc_convert(adc_convert), .wb_en(wb_en),
        .wb_idx(wb_idx), .wb_data(wb_data), .done(done), .pad_err(pad_err)
    );

    task automatic chk(input bit ok, input string req, input int got, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h at %0t", req, got, expv, $time);
        end
    endtask

    function automatic int amp_of(input logic [7:0] w);
        return (w == 8'd0) ? 1 : int'(w);
    endfunction

    function automatic logic [9:0] pad_vec(input logic [3:0] p);
        if (p >= 4'd1 && p <= 4'd10) return 10'd1 << (p - 4'd1);
        return '0;
    endfunction

    task automatic check_idle(input string req);
        chk(busy == 1'b0, req, busy, 0);
        chk(pad_en_a == '0 && pad_en_b == '0, req, {pad_en_b, pad_en_a}, 0);
        chk({adc_sample, adc_convert, wb_en, done, pad_err} == '0, req,
            {adc_sample, adc_convert, wb_en, done, pad_err}, 0);
    endtask

    task automatic run_cmd(input logic [1:0] d, input logic u, input logic [3:0] p,
                           input logic [7:0] a1, input logic [7:0] a2, input logic [7:0] a3,
                           input logic [7:0] sc, input logic [7:0] bc);
        int w, e;
        bit legal;
        logic [9:0] oh;
        logic [11:0] exp_data;
        w = amp_of(a1) + amp_of(a2) + amp_of(a3);
        e = 23 + w + int'(sc) + int'(bc);
        oh = pad_vec(p);
        legal = (oh != '0);
        exp_data = '0;
        cmd_valid = 1'b1; cmd_dst = d; cmd_unit = u; cmd_pad = p;
        cfg_amp1 = a1; cfg_amp2 = a2; cfg_amp3 = a3;
        cfg_smp_cyc = sc; cfg_bit_cyc = bc;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int k = 1; k <= e + 5; k++) begin
            bit x_busy, x_exec, x_smp, x_cnv, x_wb, x_done;
            logic [9:0] x_a, x_b;
            x_busy = (k <= e + 4);
            x_exec = (k <= e);
            x_smp  = (k >= 24 + w) && (k <= 23 + w + int'(sc));
            x_cnv  = (k >= 24 + w + int'(sc)) && (k <= e);
            x_wb   = legal && (k == e + 1);
            x_done = (k == e + 4);
            x_a    = (x_exec && !u) ? oh : '0;
            x_b    = (x_exec &&  u) ? oh : '0;
            chk(busy == x_busy, "R2 busy", busy, x_busy);
            chk(adc_sample == x_smp, "R3 sample", adc_sample, x_smp);
            chk(adc_convert == x_cnv, "R3 convert", adc_convert, x_cnv);
            chk(pad_en_a == x_a, "R4 R5 pad_en_a", pad_en_a, x_a);
            chk(pad_en_b == x_b, "R4 R5 pad_en_b", pad_en_b, x_b);
            chk(wb_en == x_wb, "R6 R8 wb_en", wb_en, x_wb);
            chk(done == x_done, "R7 done", done, x_done);
            chk(pad_err == (x_done && !legal), "R8 pad_err", pad_err, x_done && !legal);
            if (x_wb) begin
                chk(wb_idx == d, "R6 wb_idx", wb_idx, d);
                chk(wb_data == exp_data, "R6 wb_data", wb_data, exp_data);
            end
            adc_res_a = 12'($urandom);
            adc_res_b = 12'($urandom);
            if (k == e) exp_data = u ? adc_res_b : adc_res_a;
            // R9 R10: request and new settings while busy
            if (k == 3) begin
                cmd_valid = 1'b1;
                cmd_dst = 2'($urandom); cmd_unit = 1'($urandom); cmd_pad = 4'($urandom);
                cfg_amp1 = 8'($urandom); cfg_amp2 = 8'($urandom); cfg_amp3 = 8'($urandom);
                cfg_smp_cyc = 8'($urandom); cfg_bit_cyc = 8'($urandom);
            end
            if (k == 4) cmd_valid = 1'b0;
            if (k < e + 5) @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");
        // R3 clamps and both skips, first pad
        run_cmd(2'd0, 1'b0, 4'd1, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0);
        // R4 R5 last pad on second converter
        run_cmd(2'd3, 1'b1, 4'd10, 8'd5, 8'd1, 8'd2, 8'd4, 8'd12);
        // R8 pad zero and above range
        run_cmd(2'd1, 1'b0, 4'd0, 8'd2, 8'd0, 8'd3, 8'd2, 8'd2);
        run_cmd(2'd2, 1'b1, 4'd11, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1);
        // R3 sample skipped, then convert skipped
        run_cmd(2'd2, 1'b1, 4'd2, 8'd1, 8'd2, 8'd0, 8'd0, 8'd3);
        run_cmd(2'd1, 1'b0, 4'd7, 8'd0, 8'd3, 8'd1, 8'd3, 8'd0);
        for (int i = 0; i < 40; i++) begin
            logic [3:0] p;
            p = ($urandom % 5 == 0) ? 4'($urandom % 16) : 4'(1 + $urandom % 10);
            run_cmd(2'($urandom), 1'($urandom), p,
                    8'($urandom % 4), 8'($urandom % 4), 8'($urandom % 4),
                    8'($urandom % 7), 8'($urandom % 9));
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule